// File: doc/BRIEF.md
# Secondary Bus Clock Speed Mode Controller

This block belongs to a bridge that joins a primary bus to a secondary bus. It reads three static straps: a board-level 66 MHz capability strap, the primary bus 66 MHz enable, and the sampled level of the secondary bus 66 MHz enable line. From them it selects the secondary bus speed. It drives the open-drain pull-down for the secondary speed line and the two "66 MHz capable" status bits. It also produces a per-output clock enable for the secondary clock outputs. The enable either passes every primary clock cycle or every other cycle, which halves the rate.

The speed mode is captured on the first primary clock edge after primary reset is released. It then holds until the next reset, because a bus may only change its frequency above 33 MHz while in reset. The secondary reset is the combination of primary reset and a software reset control bit, and it has no clock in its path. If the power-control strap is set and the device is in its deepest power state, every secondary clock enable is forced low. A separate flag reports a strap combination that claims 66 MHz operation without the capability strap.

Top module: `sclk_mode_ctrl`

## Requirements
- R1: `stat_cap66_pri` and `stat_cap66_sec` both equal `strap_cap66` in every cycle, including during reset.
- R2: `sec_m66_pd` is 1 exactly when `strap_cap66` is 1 and `pri_m66_en` is 0. This pull-down forces the secondary bus to 33 MHz.
- R3: With both `strap_cap66` and `pri_m66_en` high at capture, `sec_m66_in` selects the secondary speed. High gives 66 MHz at full rate (`sec_speed66`=1, `sec_rate_half`=0). Low gives 33 MHz at half rate (`sec_rate_half`=1, `sec_speed66`=0).
- R4: In half-rate mode the clock enable alternates 1,0,1,0 on successive cycles. In every other locked mode it is 1 in every cycle.
- R5: A 33 MHz primary with a 66 MHz secondary is never produced. If `strap_cap66` or `pri_m66_en` was low at capture, `sec_speed66` stays 0 and the rate is full, whatever `sec_m66_in` is.
- R6: `sec_rst_n` is 0 whenever `rst_pri_n` is 0 or `bctl_sec_rst` is 1, and it follows them with no clock in between.
- R7: When `strap_pwr_clk` is 1 and `pwr_state` equals the deep-sleep code (2'b11 by default), all `sec_clk_en` bits are 0. When `strap_pwr_clk` is 0, the power state has no effect on the enables.
- R8: The mode (`sec_rate_half`, `sec_speed66` and the enable pattern) is captured on the first rising edge after `rst_pri_n` goes high. Strap changes after that edge have no effect on it until the next reset.
- R9: During reset, and in the cycle before capture, all enables, `sec_rate_half` and `sec_speed66` are 0. The first cycle after capture has the enable at 1 in every mode, so the first secondary rising edge lines up with a primary rising edge.
- R10: `mode_error` is 1 exactly when `strap_cap66` is 0 and either `pri_m66_en` or `sec_m66_in` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary clock |
| rst_pri_n | input | 1 | Primary reset, active low, asynchronous |
| strap_cap66 | input | 1 | Board strap: device may run at 66 MHz |
| pri_m66_en | input | 1 | Primary bus 66 MHz enable |
| sec_m66_in | input | 1 | Sampled level of the secondary 66 MHz enable line |
| bctl_sec_rst | input | 1 | Software secondary bus reset control bit |
| strap_pwr_clk | input | 1 | Strap allowing clock stop in the deep-sleep state |
| pwr_state | input | 2 | Device power state code |
| sec_m66_pd | output | 1 | Open-drain pull-down enable for the secondary speed line |
| stat_cap66_pri | output | 1 | Primary status 66 MHz capable bit |
| stat_cap66_sec | output | 1 | Secondary status 66 MHz capable bit |
| sec_rate_half | output | 1 | Locked mode: secondary clock at half the primary rate |
| sec_speed66 | output | 1 | Locked mode: secondary bus at 66 MHz |
| sec_clk_en | output | 10 | Clock enable, one per secondary clock output |
| sec_rst_n | output | 1 | Secondary reset, active low |
| mode_error | output | 1 | Straps claim 66 MHz without the capability strap |

## Verification
A mode register captured from the wrong straps, or loaded again after the first edge, shows up in the next cycle as a wrong `sec_rate_half` or `sec_speed66` and a wrong enable pattern. A divider phase that is out of step shows in the first cycle after capture as an enable of 0, where the first edge must line up. A stuck phase shows one cycle later as two equal enables in a row. The gating and the status, pull-down, error and reset paths are combinational, so a fault in them shows at the ports in the same cycle. The bench keeps a behavioural model of the captured mode and a count of edges since capture, and compares every output at each falling edge.

// File: rtl/sclk_mode_pkg.sv
package sclk_mode_pkg;

   typedef struct packed {
      logic half;   // secondary runs at half the primary rate
      logic s66;    // secondary bus at 66 MHz
   } speed_mode_t;

   localparam speed_mode_t MODE_IDLE = '{half: 1'b0, s66: 1'b0};

endpackage

// File: rtl/sclk_mode_decode.sv
module sclk_mode_decode
   import sclk_mode_pkg::*;
(
   input  logic        cap66,
   input  logic        pri_en,
   input  logic        sec_in,
   output speed_mode_t mode_nxt,
   output logic        pull_dn,
   output logic        cap_stat,
   output logic        cfg_err
);
   logic pri_fast;
   logic sec_fast;

   // the primary counts as fast only if the board allows it
   assign pri_fast = cap66 & pri_en;
   // a slow primary forces a slow secondary: the 33/66 pair cannot occur
   assign sec_fast = pri_fast & sec_in;

   always_comb begin
      mode_nxt      = MODE_IDLE;
      mode_nxt.s66  = sec_fast;
      mode_nxt.half = pri_fast & ~sec_fast;
   end

   assign pull_dn  = cap66 & ~pri_en;
   assign cap_stat = cap66;
   assign cfg_err  = ~cap66 & (pri_en | sec_in);

endmodule

// File: rtl/sclk_mode_latch.sv
module sclk_mode_latch
   import sclk_mode_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  speed_mode_t mode_nxt,
   output speed_mode_t mode_q,
   output logic        locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
         mode_q <= MODE_IDLE;
      end else if (!locked) begin
         locked <= 1'b1;
         mode_q <= mode_nxt;
      end
   end

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(mode_q) && locked); // R8

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic locked,
   input  logic half,
   output logic base_en
);
   logic phase_q;

   // phase 0 carries the enable, so the first locked cycle is always active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= 1'b0;
      else if (locked && half)
         phase_q <= ~phase_q;
      else
         phase_q <= 1'b0;
   end

   assign base_en = locked & (~half | ~phase_q);

   AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> base_en); // R9
   AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && half && $past(locked)) |-> (base_en != $past(base_en))); // R4
   AST_FULL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !half) |-> base_en); // R4

endmodule

// File: rtl/sclk_out_gate.sv
module sclk_out_gate #(
   parameter int NUM_OUT = 10
) (
   input  logic               base_en,
   input  logic               stop,
   output logic [NUM_OUT-1:0] out_en
);
   generate
      if (NUM_OUT < 1) begin : g_bad_cfg
         $error("sclk_out_gate: NUM_OUT must be at least 1");
      end
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
         assign out_en[i] = base_en & ~stop;
      end
   endgenerate

endmodule

// File: rtl/sclk_mode_ctrl.sv
module sclk_mode_ctrl
   import sclk_mode_pkg::*;
#(
   parameter int          NUM_SEC_CLK = 10,
   parameter int          PSTATE_W    = 2,
   parameter logic [PSTATE_W-1:0] SLEEP_CODE = '1
) (
   input  logic                   clk_pri,
   input  logic                   rst_pri_n,
   input  logic                   strap_cap66,
   input  logic                   pri_m66_en,
   input  logic                   sec_m66_in,
   input  logic                   bctl_sec_rst,
   input  logic                   strap_pwr_clk,
   input  logic [PSTATE_W-1:0]    pwr_state,
   output logic                   sec_m66_pd,
   output logic                   stat_cap66_pri,
   output logic                   stat_cap66_sec,
   output logic                   sec_rate_half,
   output logic                   sec_speed66,
   output logic [NUM_SEC_CLK-1:0] sec_clk_en,
   output logic                   sec_rst_n,
   output logic                   mode_error
);
   localparam int STATE_COUNT = 1 << PSTATE_W;

   generate
      if (PSTATE_W < 1) begin : g_bad_pw
         $error("sclk_mode_ctrl: PSTATE_W must be at least 1");
      end
      if (int'(SLEEP_CODE) >= STATE_COUNT) begin : g_bad_code
         $error("sclk_mode_ctrl: SLEEP_CODE out of range");
      end
   endgenerate

   speed_mode_t mode_nxt;
   speed_mode_t mode_q;
   logic        lock_q;
   logic        cap_stat;
   logic        base_en;
   logic        clk_stop;

   sclk_mode_decode i_decode (
      .cap66    (strap_cap66),
      .pri_en   (pri_m66_en),
      .sec_in   (sec_m66_in),
      .mode_nxt (mode_nxt),
      .pull_dn  (sec_m66_pd),
      .cap_stat (cap_stat),
      .cfg_err  (mode_error)
   );

   sclk_mode_latch i_latch (
      .clk      (clk_pri),
      .rst_n    (rst_pri_n),
      .mode_nxt (mode_nxt),
      .mode_q   (mode_q),
      .locked   (lock_q)
   );

   sclk_rate_gen i_rate (
      .clk      (clk_pri),
      .rst_n    (rst_pri_n),
      .locked   (lock_q),
      .half     (mode_q.half),
      .base_en  (base_en)
   );

   assign clk_stop = strap_pwr_clk & (pwr_state == SLEEP_CODE);

   sclk_out_gate #(.NUM_OUT(NUM_SEC_CLK)) i_gate (
      .base_en  (base_en),
      .stop     (clk_stop),
      .out_en   (sec_clk_en)
   );

   assign stat_cap66_pri = cap_stat;
   assign stat_cap66_sec = cap_stat;
   assign sec_rate_half  = mode_q.half;
   assign sec_speed66    = mode_q.s66;
   // no clock in this path: the secondary reset follows its sources at once
   assign sec_rst_n      = rst_pri_n & ~bctl_sec_rst;

   AST_PULLDOWN: assert property (@(posedge clk_pri) disable iff (!rst_pri_n)
      (strap_cap66 && !pri_m66_en) |-> sec_m66_pd); // R2
   AST_NO_SLOW_FAST: assert property (@(posedge clk_pri) disable iff (!rst_pri_n)
      !lock_q |=> (!sec_speed66 || ($past(strap_cap66) && $past(pri_m66_en)))); // R5
   AST_SLEEP_GATED: assert property (@(posedge clk_pri) disable iff (!rst_pri_n)
      (strap_pwr_clk && pwr_state == SLEEP_CODE) |-> (sec_clk_en == '0)); // R7
   AST_WAKE_RUNS: assert property (@(posedge clk_pri) disable iff (!rst_pri_n)
      (!strap_pwr_clk && lock_q && !sec_rate_half) |-> (sec_clk_en == '1)); // R7

endmodule

// File: tb/test_sclk_mode_ctrl.sv
module test_sclk_mode_ctrl;
   localparam int NCLK = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cap = 1'b0, pri = 1'b0, sec = 1'b0, bctl = 1'b0, pstrap = 1'b0;
   logic [1:0]      pstate = 2'b00;
   logic            pd, st_p, st_s, half, s66, srst_n, err;
   logic [NCLK-1:0] en;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // reference model state
   bit m_locked = 0;
   bit m_half = 0;
   bit m_s66 = 0;
   int m_k = 0;

   always #2 clk = ~clk;

   sclk_mode_ctrl #(.NUM_SEC_CLK(NCLK)) i_sclk_mode_ctrl (
      .clk_pri(clk), .rst_pri_n(rst_n), .strap_cap66(cap), .pri_m66_en(pri),
      .sec_m66_in(sec), .bctl_sec_rst(bctl), .strap_pwr_clk(pstrap),
      .pwr_state(pstate), .sec_m66_pd(pd), .stat_cap66_pri(st_p),
      .stat_cap66_sec(st_s), .sec_rate_half(half), .sec_speed66(s66),
      .sec_clk_en(en), .sec_rst_n(srst_n), .mode_error(err)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // model: capture on the first edge with reset released, then count edges
   always @(posedge clk) begin
      if (!rst_n) begin
         m_locked = 0; m_half = 0; m_s66 = 0; m_k = 0;
      end else if (!m_locked) begin
         m_locked = 1;
         m_s66  = cap && pri && sec;
         m_half = cap && pri && !sec;
         m_k = 0;
      end else begin
         m_k++;
      end
   end

   always @(negedge clk) begin
      bit stop_e;
      bit en_e;
      if (!done) begin
         stop_e = pstrap && (pstate == 2'b11);
         en_e = m_locked && (!m_half || (m_k % 2 == 0)) && !stop_e;
         chk("R1 stat pri", 16'(st_p), 16'(cap));
         chk("R1 stat sec", 16'(st_s), 16'(cap));
         chk("R2 pulldown", 16'(pd), 16'(cap && !pri));
         chk("R3 R8 R9 half", 16'(half), 16'(m_locked && m_half));
         chk("R3 R5 R8 speed66", 16'(s66), 16'(m_locked && m_s66));
         chk("R4 R7 R9 enables", 16'(en), en_e ? 16'({NCLK{1'b1}}) : 16'd0);
         chk("R6 sec reset", 16'(srst_n), 16'(rst_n && !bctl));
         chk("R10 mode error", 16'(err), 16'(!cap && (pri || sec)));
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic restart(input logic c, input logic p, input logic s);
      rst_n = 1'b0;
      cap = c; pri = p; sec = s;
      step(3);
      rst_n = 1'b1;
      step(9);
   endtask

   initial begin
      step(4);                       // reset state: R9 enables low, R6 reset low
      restart(1, 1, 1);              // R3 66/66 full rate
      restart(1, 1, 0);              // R3 R4 66/33 half rate
      restart(1, 0, 0);              // R2 33/33 with pull-down
      restart(1, 0, 1);              // R5 33/66 request rejected
      restart(0, 1, 1);              // R10 error, forced slow
      restart(0, 0, 0);
      restart(1, 1, 0);              // R8 straps change after capture
      cap = 1'b1; pri = 1'b1; sec = 1'b1;
      step(5);
      cap = 1'b1; pri = 1'b0; sec = 1'b0;
      step(5);
      restart(1, 1, 0);              // R7 sleep gating with strap low, then high
      pstate = 2'b11; pstrap = 1'b0;
      step(5);
      pstrap = 1'b1;
      step(5);
      pstate = 2'b10;
      step(4);
      pstate = 2'b00; pstrap = 1'b0;
      restart(1, 1, 1);
      pstrap = 1'b1; pstate = 2'b11;
      step(3);
      pstrap = 1'b0; pstate = 2'b00;
      bctl = 1'b1;                   // R6 software secondary reset
      step(3);
      bctl = 1'b0;
      step(3);
      rst_n = 1'b0;                  // R6 R9 reset in mid-run
      step(2);
      rst_n = 1'b1;
      step(6);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule